// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler

This block sits in a DDR SDRAM controller and decides when the memory must be refreshed. A free-running timer marks the end of each average refresh interval and adds one owed refresh to a small debt counter. While any refresh is owed, the block raises a request to the controller's command-bus arbiter. Once the arbiter grants the bus, the block closes any open rows with a precharge-all command, waits out the row precharge time, issues an auto-refresh, and keeps the bus until the refresh cycle time has elapsed. It then releases the bus, or goes straight into the next refresh if more are owed.

The debt is capped. Up to eight refreshes may be postponed while the arbiter serves other traffic. When the cap is reached, an urgent flag tells the arbiter to stop deferring. Every cycle in which no precharge or refresh is driven carries a NOP on the encoded command output. The arbiter is expected to keep the grant high for as long as the request stays high.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and right after it, the command output is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), and both bus_req and bus_urgent are low.
- R2: The interval timer counts from reset release. Its first owed refresh becomes visible after exactly REFI_CYC rising edges, and one more follows every REFI_CYC edges after that.
- R3: bus_req is high whenever at least one refresh is owed or a precharge/refresh sequence is in progress, and low otherwise.
- R4: bus_urgent is high exactly when the owed count equals MAX_DEBT, and falls in the cycle after a refresh brings the count below it.
- R5: The owed count saturates at MAX_DEBT. A timer expiry that arrives at the cap is dropped, so a fully postponed backlog drains with exactly MAX_DEBT refreshes.
- R6: If any bit of bank_open is set when the grant is seen in the idle state, the next cycle drives precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1).
- R7: The auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0) follows a precharge-all exactly RP_CYC cycles later, with NOPs in between.
- R8: After an auto-refresh, no command is driven for RFC_CYC cycles. A back-to-back refresh follows the previous one after RFC_CYC+1 cycles.
- R9: If no bank is open when the grant is seen in the idle state, the auto-refresh is driven in the very next cycle, with no precharge.
- R10: No command other than NOP is driven while the grant is low and no sequence has started.
- R11: Each auto-refresh retires one owed refresh. After the last one, bus_req falls RFC_CYC cycles after that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_open | input | NUM_BANKS | One bit per bank, set while that bank has an open row |
| bus_gnt | input | 1 | Arbiter grant of the command bus |
| bus_req | output | 1 | Request for the command bus |
| bus_urgent | output | 1 | Owed refreshes have reached the cap |
| cmd_cs_n | output | 1 | Encoded command: chip select, active low |
| cmd_ras_n | output | 1 | Encoded command: row strobe, active low |
| cmd_cas_n | output | 1 | Encoded command: column strobe, active low |
| cmd_we_n | output | 1 | Encoded command: write enable, active low |
| cmd_a10 | output | 1 | Encoded command: address bit 10 (all-bank select) |

## Verification
The bench builds the block with REFI_CYC=80, RP_CYC=3, RFC_CYC=6, MAX_DEBT=8 and NUM_BANKS=4. The short interval makes it possible to fill the debt to its cap and push one more expiry into saturation in under a thousand cycles. An interval longer than eight back-to-back refresh windows (8 x 7 = 56 cycles) lets the whole backlog drain with no new expiry arriving in the middle. Because of this, refresh counts and the exact cycle at which the request falls are fully predictable.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [2:0] {
    RS_IDLE = 3'd0,
    RS_PREA = 3'd1,
    RS_TRP  = 3'd2,
    RS_REF  = 3'd3,
    RS_TRFC = 3'd4
  } rs_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam ddr_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam ddr_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
  parameter int unsigned PERIOD = 1040
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(PERIOD - 1));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  // R2: an expiry lasts one cycle, never two in a row
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic consume,
  output logic owed,
  output logic full
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);

  logic [DW-1:0] debt_q, debt_d;
  logic          add, sub, debt_en;

  always_comb begin
    full    = (debt_q == DW'(MAX_DEBT));
    owed    = (debt_q != '0);
    add     = tick && !full;
    sub     = consume && owed;
    debt_en = add ^ sub;
    debt_d  = add ? debt_q + 1'b1 : debt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       debt_q <= '0;
    else if (debt_en) debt_q <= debt_d;
  end

  // R5: never above the cap
  a_r5_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DW'(MAX_DEBT));

  // R11: a refresh with no simultaneous expiry retires one owed refresh
  a_r11_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !tick && owed) |=> (debt_q == $past(debt_q) - 1'b1));

  // R5: an expiry at the cap leaves the count at the cap
  a_r5_drop_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && tick && !consume) |=> full);

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
  import refsch_pkg::*;
#(
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned RFC_CYC = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     owed,
  input  logic     bus_gnt,
  input  logic     any_open,
  output ddr_cmd_t cmd,
  output logic     busy,
  output logic     ref_fire
);
  localparam int unsigned WMAX = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
  localparam int unsigned WW   = (WMAX > 2) ? $clog2(WMAX) : 1;
  localparam bit          RP_WAIT  = (RP_CYC  > 1);
  localparam bit          RFC_WAIT = (RFC_CYC > 1);

  rs_state_e     st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          wcnt_en;

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (owed && bus_gnt) st_d = any_open ? RS_PREA : RS_REF;
      end
      RS_PREA: begin
        if (RP_WAIT) begin
          st_d    = RS_TRP;
          wcnt_d  = WW'(RP_CYC - 1);
          wcnt_en = 1'b1;
        end else begin
          st_d = RS_REF;
        end
      end
      RS_TRP: begin
        if (wcnt_q == WW'(1)) begin
          st_d = RS_REF;
        end else begin
          wcnt_d  = wcnt_q - 1'b1;
          wcnt_en = 1'b1;
        end
      end
      RS_REF: begin
        if (RFC_WAIT) begin
          st_d    = RS_TRFC;
          wcnt_d  = WW'(RFC_CYC - 1);
          wcnt_en = 1'b1;
        end else begin
          st_d = RS_IDLE;
        end
      end
      RS_TRFC: begin
        if (wcnt_q == WW'(1)) begin
          st_d = RS_IDLE;
        end else begin
          wcnt_d  = wcnt_q - 1'b1;
          wcnt_en = 1'b1;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      RS_PREA: cmd = CMD_PREA;
      RS_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
    busy     = (st_q != RS_IDLE);
    ref_fire = (st_q == RS_REF);
  end

  // R6: a precharge-all is always followed by the rest of the sequence
  a_r6_prea_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_PREA) |=> (st_q == RS_TRP || st_q == RS_REF));

  // R9: a refresh straight from idle only when nothing was open
  a_r9_direct_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_IDLE && owed && bus_gnt && !any_open) |=> (st_q == RS_REF));

  // R10: leaving idle needs a grant
  a_r10_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_IDLE && !bus_gnt) |=> (st_q == RS_IDLE));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsch_pkg::*;
#(
  parameter int unsigned REFI_CYC  = 1040,
  parameter int unsigned RFC_CYC   = 10,
  parameter int unsigned RP_CYC    = 3,
  parameter int unsigned MAX_DEBT  = 8,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 bus_gnt,
  output logic                 bus_req,
  output logic                 bus_urgent,
  output logic                 cmd_cs_n,
  output logic                 cmd_ras_n,
  output logic                 cmd_cas_n,
  output logic                 cmd_we_n,
  output logic                 cmd_a10
);
  logic     tick, owed, full, busy, ref_fire;
  ddr_cmd_t cmd;

  refsch_interval #(.PERIOD(REFI_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  refsch_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .consume(ref_fire),
    .owed   (owed),
    .full   (full)
  );

  refsch_seq #(.RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .owed    (owed),
    .bus_gnt (bus_gnt),
    .any_open(|bank_open),
    .cmd     (cmd),
    .busy    (busy),
    .ref_fire(ref_fire)
  );

  assign bus_req    = owed | busy;
  assign bus_urgent = full;
  assign cmd_cs_n   = cmd.cs_n;
  assign cmd_ras_n  = cmd.ras_n;
  assign cmd_cas_n  = cmd.cas_n;
  assign cmd_we_n   = cmd.we_n;
  assign cmd_a10    = cmd.a10;

  // Spacing monitor on the command output, used only by the assertions
  localparam int unsigned SAT = (RFC_CYC > RP_CYC) ? RFC_CYC : RP_CYC;
  localparam int unsigned SW  = $clog2(SAT + 1);

  logic          issued, is_ref, is_pre;
  logic [SW-1:0] since_q;
  logic          last_ref_q, last_pre_q;

  always_comb begin
    is_ref = (cmd == CMD_REF);
    is_pre = (cmd == CMD_PREA);
    issued = is_ref || is_pre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= SW'(SAT);
      last_ref_q <= 1'b0;
      last_pre_q <= 1'b0;
    end else if (issued) begin
      since_q    <= SW'(1);
      last_ref_q <= is_ref;
      last_pre_q <= is_pre;
    end else if (since_q < SW'(SAT)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R7: refresh only after the precharge time has elapsed
  a_r7_trp_met: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_pre_q) |-> (since_q >= SW'(RP_CYC)));

  // R8: nothing inside the refresh cycle time
  a_r8_trfc_met: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && last_ref_q) |-> (since_q >= SW'(RFC_CYC)));

  // R4: urgency always comes with a request
  a_r4_urgent_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_urgent |-> bus_req);

  // R10: commands only while the bus is requested and granted
  a_r10_cmd_owned: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> (bus_req && $past(bus_req)));

  // R3: an empty debt with no sequence leaves the bus alone
  a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!owed && !busy) |-> !bus_req);

endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;

  localparam int REFI = 80;
  localparam int RP   = 3;
  localparam int RFC  = 6;
  localparam int MAXD = 8;
  localparam int NB   = 4;

  localparam logic [4:0] V_NOP  = 5'b01110;
  localparam logic [4:0] V_PREA = 5'b00101;
  localparam logic [4:0] V_REF  = 5'b00010;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] bank_open;
  logic          bus_gnt;
  logic          bus_req, bus_urgent;
  logic          cs_n, ras_n, cas_n, we_n, a10;
  logic [4:0]    cmd_v;
  int            cyc;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #5 clk = ~clk;

  refresh_sched #(
    .REFI_CYC(REFI), .RFC_CYC(RFC), .RP_CYC(RP), .MAX_DEBT(MAXD), .NUM_BANKS(NB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .bus_urgent(bus_urgent),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_a10(a10)
  );

  assign cmd_v = {cs_n, ras_n, cas_n, we_n, a10};

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic goto(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bank_open = '0; bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_v == V_NOP, "R1 cmd in reset", cmd_v, V_NOP);
    chk(!bus_req && !bus_urgent, "R1 req/urgent in reset", {bus_req, bus_urgent}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_v == V_NOP && !bus_req, "R1 after release", {bus_req, cmd_v}, V_NOP);
  endtask

  task automatic t_closed_refresh;
    int bad = 0;
    goto(REFI - 1);
    chk(!bus_req, "R2 no debt before interval", bus_req, 0);
    goto(REFI);
    chk(bus_req, "R2 R3 request after interval", bus_req, 1);
    chk(!bus_urgent, "R4 not urgent at one owed", bus_urgent, 0);
    bus_gnt = 1'b1;
    goto(REFI + 1);
    chk(cmd_v == V_REF, "R9 direct refresh", cmd_v, V_REF);
    for (int n = REFI + 2; n <= REFI + RFC; n++) begin
      goto(n);
      if (cmd_v != V_NOP || !bus_req) bad++;
    end
    chk(bad == 0, "R8 quiet and held during tRFC", bad, 0);
    goto(REFI + 1 + RFC);
    chk(!bus_req, "R11 release after refresh", bus_req, 0);
    bus_gnt = 1'b0;
  endtask

  task automatic t_open_refresh;
    bank_open = 4'b0101;
    goto(2 * REFI);
    bus_gnt = 1'b1;
    goto(2 * REFI + 1);
    chk(cmd_v == V_PREA, "R6 precharge-all first", cmd_v, V_PREA);
    bank_open = '0;
    goto(2 * REFI + 2);
    chk(cmd_v == V_NOP, "R7 nop during tRP", cmd_v, V_NOP);
    goto(2 * REFI + RP);
    chk(cmd_v == V_NOP, "R7 nop at end of tRP", cmd_v, V_NOP);
    goto(2 * REFI + 1 + RP);
    chk(cmd_v == V_REF, "R7 refresh after tRP", cmd_v, V_REF);
    goto(2 * REFI + 1 + RP + RFC - 1);
    chk(bus_req, "R3 held through tRFC", bus_req, 1);
    goto(2 * REFI + 1 + RP + RFC);
    chk(!bus_req, "R11 release after sequence", bus_req, 0);
    bus_gnt = 1'b0;
  endtask

  task automatic t_saturate_drain;
    int bad = 0;
    int nref = 0;
    int gap_bad = 0;
    int last = 0;
    int full_at = 2 * REFI + MAXD * REFI;
    int start = full_at + REFI;
    for (int n = 2 * REFI + RP + RFC + 2; n <= start; n++) begin
      goto(n);
      if (cmd_v != V_NOP) bad++;
      if (n == full_at - 1) chk(!bus_urgent, "R4 below cap", bus_urgent, 0);
      if (n == full_at)     chk(bus_urgent, "R4 at cap", bus_urgent, 1);
    end
    chk(bad == 0, "R10 no command without grant", bad, 0);
    chk(bus_urgent && bus_req, "R5 still at cap after extra expiry", {bus_req, bus_urgent}, 3);
    bus_gnt = 1'b1;
    for (int n = start + 1; n <= start + 60; n++) begin
      goto(n);
      if (cmd_v == V_REF) begin
        if (nref > 0 && (n - last) != RFC + 1) gap_bad++;
        if (nref == 0 && n != start + 1) gap_bad++;
        last = n;
        nref++;
      end else if (cmd_v != V_NOP) begin
        bad++;
      end
      if (n == start + 2) chk(!bus_urgent, "R4 urgent drops after refresh", bus_urgent, 0);
      if (n == start + 1 + (MAXD - 1) * (RFC + 1) + RFC - 1)
        chk(bus_req, "R11 held in last tRFC", bus_req, 1);
      if (n == start + 1 + (MAXD - 1) * (RFC + 1) + RFC)
        chk(!bus_req, "R11 release after backlog", bus_req, 0);
    end
    chk(nref == MAXD, "R5 backlog drains with cap count", nref, MAXD);
    chk(gap_bad == 0, "R8 back-to-back spacing", gap_bad, 0);
    chk(bad == 0, "R9 no precharge with banks closed", bad, 0);
    bus_gnt = 1'b0;
  endtask

  initial begin
    t_reset();
    t_closed_refresh();
    t_open_refresh();
    t_saturate_drain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule